// File: doc/BRIEF.md
# Saturating Wide-Dividend Divider

This block divides a double-width dividend by a single-width divisor and returns a single-width quotient that is clamped rather than truncated when it does not fit. The dividend is the concatenation of a high word (`y_hi`, upper half) and a low word (`lo_in`, lower half). The divisor is one word. `signed_mode` selects unsigned or two's-complement operation. The remainder is discarded.

A request is made by raising `start` for one cycle while the block is idle. The block latches its operands and the mode. It produces one quotient bit per cycle by restoring division on magnitudes. It then applies the sign and the saturation rule, and signals completion with a single-cycle `done` pulse. The result, an overflow flag and negative/zero condition flags are held on the outputs until the next completion. A zero divisor does not start an iteration. It completes at once on a dedicated error output. All behaviour below is stated for the default `WIDTH` of 32.

Top module: `sat_divider`

## Requirements
- R1: While `rst_n` is low, `busy`, `done`, `ovf`, `neg_flag`, `zero_flag`, `div_zero` are 0 and `quotient` is 0.
- R2: With `signed_mode`=0, the dividend is {`y_hi`,`lo_in`} taken as an unsigned 64-bit number. When the exact quotient is at most 0xFFFFFFFF, `quotient` equals it and `ovf` is 0.
- R3: With `signed_mode`=0, when the exact quotient exceeds 0xFFFFFFFF, `quotient` is 0xFFFFFFFF and `ovf` is 1.
- R4: With `signed_mode`=1, dividend and divisor are two's complement and the quotient is rounded toward zero. When it lies in [-2^31, 2^31-1], `quotient` is its 32-bit two's-complement value and `ovf` is 0.
- R5: With `signed_mode`=1 and a quotient outside that range, `quotient` is 0x80000000 for a negative quotient and 0x7FFFFFFF for a positive one, and `ovf` is 1.
- R6: On every completion, `neg_flag` equals bit 31 of the new `quotient` and `zero_flag` is 1 exactly when the new `quotient` is 0.
- R7: A `start` accepted with `divisor`=0 raises `done` and `div_zero` in the next cycle without raising `busy`, with `quotient`=0, `ovf`=0, `neg_flag`=0, `zero_flag`=1.
- R8: A `start` accepted with a nonzero divisor raises `busy` from the next cycle. `done` is high for exactly one cycle, 65 rising edges after the accepting edge, and `busy` falls in that same cycle.
- R9: `start`, operand and mode changes while `busy` is high have no effect on the running division or its timing.
- R10: Outputs hold their values between completions. `div_zero` returns to 0 at the next completion with a nonzero divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only while idle |
| signed_mode | input | 1 | 1 = two's-complement division, 0 = unsigned |
| y_hi | input | 32 | Upper half of the dividend |
| lo_in | input | 32 | Lower half of the dividend |
| divisor | input | 32 | Divisor |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | 32 | Saturated quotient |
| ovf | output | 1 | Quotient was clamped |
| neg_flag | output | 1 | Bit 31 of the result |
| zero_flag | output | 1 | Result is zero |
| div_zero | output | 1 | Last request had a zero divisor |

## Verification
The bound assertions check the handshake on every cycle. They cover the one-cycle `done` pulse, the exclusion of `busy` and `done`, and `busy` falling only with `done`. They also cover acceptance of a start, the immediate zero-divisor completion, and the saturated values that any overflowing completion must carry in each mode. The numeric quotients cannot be checked that way. These include the exact results near the signed and unsigned range edges, rounding toward zero for every sign combination, the 65-edge latency, immunity to a second start and to operand changes while busy, and the clearing of `div_zero`. The bench's scenarios show them by comparing against its behavioural reference every clock.

// File: rtl/sat_divider.sv
module sat_divider #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             signed_mode,
  input  logic [WIDTH-1:0] y_hi,
  input  logic [WIDTH-1:0] lo_in,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic             ovf,
  output logic             neg_flag,
  output logic             zero_flag,
  output logic             div_zero
);
  localparam int DW = 2 * WIDTH;
  localparam int CW = $clog2(DW + 1);
  localparam logic [DW-1:0]    NEG_LIM = DW'(1) << (WIDTH - 1);
  localparam logic [DW-1:0]    POS_LIM = NEG_LIM - DW'(1);
  localparam logic [WIDTH-1:0] MIN_VAL = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MAX_VAL = ~MIN_VAL;

  logic             busy_q, done_q, mode_q, neg_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH:0]   rem_q;
  logic [DW-1:0]    acc_q;
  logic [WIDTH-1:0] dmag_q;
  logic [WIDTH-1:0] quo_q;
  logic             ovf_q, n_q, z_q, dz_q;

  wire [DW-1:0]    dividend = {y_hi, lo_in};
  wire             dvd_neg  = signed_mode & y_hi[WIDTH-1];
  wire             dvs_neg  = signed_mode & divisor[WIDTH-1];
  wire [DW-1:0]    dvd_mag  = dvd_neg ? (~dividend + DW'(1)) : dividend;
  wire [WIDTH-1:0] dvs_mag  = dvs_neg ? (~divisor + WIDTH'(1)) : divisor;
  wire             zero_div = (divisor == '0);

  wire [WIDTH:0]   shifted = {rem_q[WIDTH-1:0], acc_q[DW-1]};
  wire [WIDTH+1:0] diff    = {1'b0, shifted} - {2'b00, dmag_q};
  wire             take    = ~diff[WIDTH+1];
  wire             last    = (cnt_q == CW'(DW));

  logic [WIDTH-1:0] sat_val;
  logic             sat_ovf;

  always_comb begin
    if (!mode_q) begin
      sat_ovf = |acc_q[DW-1:WIDTH];
      sat_val = sat_ovf ? '1 : acc_q[WIDTH-1:0];
    end else if (neg_q) begin
      sat_ovf = acc_q > NEG_LIM;
      sat_val = sat_ovf ? MIN_VAL : (~acc_q[WIDTH-1:0] + WIDTH'(1));
    end else begin
      sat_ovf = acc_q > POS_LIM;
      sat_val = sat_ovf ? MAX_VAL : acc_q[WIDTH-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= 1'b0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
      dmag_q <= '0;
      quo_q  <= '0;
      ovf_q  <= 1'b0;
      n_q    <= 1'b0;
      z_q    <= 1'b0;
      dz_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          quo_q  <= sat_val;
          ovf_q  <= sat_ovf;
          n_q    <= sat_val[WIDTH-1];
          z_q    <= (sat_val == '0);
          dz_q   <= 1'b0;
        end else begin
          rem_q <= take ? diff[WIDTH:0] : shifted;
          acc_q <= {acc_q[DW-2:0], take};
          cnt_q <= cnt_q + CW'(1);
        end
      end else if (start) begin
        if (zero_div) begin
          done_q <= 1'b1;
          dz_q   <= 1'b1;
          quo_q  <= '0;
          ovf_q  <= 1'b0;
          n_q    <= 1'b0;
          z_q    <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= '0;
          rem_q  <= '0;
          acc_q  <= dvd_mag;
          dmag_q <= dvs_mag;
          mode_q <= signed_mode;
          neg_q  <= dvd_neg ^ dvs_neg;
        end
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign quotient  = quo_q;
  assign ovf       = ovf_q;
  assign neg_flag  = n_q;
  assign zero_flag = z_q;
  assign div_zero  = dz_q;
endmodule

// File: rtl/sat_divider_chk.sv
module sat_divider_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [WIDTH-1:0] divisor,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] quotient,
  input logic             ovf,
  input logic             div_zero,
  input logic             mode_q
);
  localparam logic [WIDTH-1:0] MIN_VAL = {1'b1, {(WIDTH-1){1'b0}}};
  localparam logic [WIDTH-1:0] MAX_VAL = ~MIN_VAL;

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);
  assert_busy_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  assert_busy_ends_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (divisor != '0) |=> busy);
  assert_div_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (divisor == '0) |=> done && div_zero && !busy);
  assert_unsigned_sat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done && ovf && !mode_q |-> quotient == '1);
  assert_signed_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && ovf && mode_q |-> (quotient == MIN_VAL) || (quotient == MAX_VAL));
  assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> busy || done);
endmodule

bind sat_divider sat_divider_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
  .busy(busy), .done(done), .quotient(quotient), .ovf(ovf),
  .div_zero(div_zero), .mode_q(mode_q)
);

// File: tb/test_sat_divider.sv
`timescale 1ns/1ps
module test_sat_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        signed_mode = 1'b0;
  logic [31:0] y_hi = '0, lo_in = '0, divisor = 32'd1;
  logic        busy, done, ovf, neg_flag, zero_flag, div_zero;
  logic [31:0] quotient;

  always #2 clk = ~clk;

  sat_divider i_sat_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
    .y_hi(y_hi), .lo_in(lo_in), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .ovf(ovf), .neg_flag(neg_flag), .zero_flag(zero_flag),
    .div_zero(div_zero)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit cmp_en = 1'b0;
  string cur_tag = "R2";

  function automatic logic [32:0] ref_div(logic [31:0] hi, logic [31:0] lo,
                                          logic [31:0] dv, logic sm);
    logic [63:0] a, ma, qm, t;
    logic [31:0] mb;
    logic ng;
    a = {hi, lo};
    if (!sm) begin
      qm = a / {32'd0, dv};
      if (qm > 64'hFFFF_FFFF) return {1'b1, 32'hFFFF_FFFF};
      return {1'b0, qm[31:0]};
    end
    ma = hi[31] ? (64'd0 - a) : a;
    mb = dv[31] ? (32'd0 - dv) : dv;
    ng = hi[31] ^ dv[31];
    qm = ma / {32'd0, mb};
    if (ng) begin
      if (qm > 64'h8000_0000) return {1'b1, 32'h8000_0000};
      t = 64'd0 - qm;
      return {1'b0, t[31:0]};
    end
    if (qm > 64'h7FFF_FFFF) return {1'b1, 32'h7FFF_FFFF};
    return {1'b0, qm[31:0]};
  endfunction

  logic        m_busy, m_done, m_ovf, m_n, m_z, m_dz, p_ovf;
  logic [31:0] m_q, p_q;
  int          m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_ovf <= 0; m_n <= 0; m_z <= 0; m_dz <= 0;
      m_q <= 0; p_q <= 0; p_ovf <= 0; m_cnt <= 0;
    end else begin
      m_done <= 0;
      if (m_busy) begin
        if (m_cnt == 1) begin
          m_busy <= 0; m_done <= 1; m_q <= p_q; m_ovf <= p_ovf;
          m_n <= p_q[31]; m_z <= (p_q == 0); m_dz <= 0;
        end else m_cnt <= m_cnt - 1;
      end else if (start) begin
        if (divisor == 0) begin
          m_done <= 1; m_dz <= 1; m_q <= 0; m_ovf <= 0; m_n <= 0; m_z <= 1;
        end else begin
          logic [32:0] r;
          r = ref_div(y_hi, lo_in, divisor, signed_mode);
          m_busy <= 1; m_cnt <= 65; p_q <= r[31:0]; p_ovf <= r[32];
        end
      end
    end
  end

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_en) begin
    check("R8", "busy", busy, m_busy);
    check("R8", "done", done, m_done);
    check(cur_tag, "quotient", quotient, m_q);
    check(cur_tag, "ovf", ovf, m_ovf);
    check("R6", "neg_flag", neg_flag, m_n);
    check("R6", "zero_flag", zero_flag, m_z);
    check("R7", "div_zero", div_zero, m_dz);
  end

  task automatic run(string tag, logic [31:0] hi, logic [31:0] lo,
                     logic [31:0] dv, logic sm);
    @(negedge clk);
    cur_tag = tag;
    y_hi = hi; lo_in = lo; divisor = dv; signed_mode = sm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (68) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "quotient", quotient, 0);
    check("R1", "ovf", ovf, 0);
    check("R1", "flags", {neg_flag, zero_flag, div_zero}, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    run("R2", 32'd0, 32'd100, 32'd7, 0);
    run("R2", 32'd1, 32'd0, 32'd2, 0);
    run("R2", 32'd0, 32'd3, 32'd5, 0);
    run("R2", 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run("R3", 32'd2, 32'd0, 32'd1, 0);
    run("R3", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd3, 0);
    run("R4", 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2, 1);
    run("R4", 32'd0, 32'd7, 32'hFFFF_FFFE, 1);
    run("R4", 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 1);
    run("R4", 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 1);
    run("R4", 32'd0, 32'h7FFF_FFFF, 32'd1, 1);
    run("R5", 32'd0, 32'h8000_0000, 32'd1, 1);
    run("R5", 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1, 1);
    run("R5", 32'h8000_0000, 32'd0, 32'hFFFF_FFFF, 1);
    run("R5", 32'd5, 32'd0, 32'hFFFF_FFFF, 1);
    run("R7", 32'd9, 32'd9, 32'd0, 0);
    run("R7", 32'hFFFF_FFFF, 32'd1, 32'd0, 1);
    run("R10", 32'd0, 32'd40, 32'd8, 0);

    @(negedge clk);
    cur_tag = "R9";
    y_hi = 32'd0; lo_in = 32'd1000; divisor = 32'd10; signed_mode = 0; start = 1;
    @(negedge clk);
    start = 0;
    repeat (10) @(negedge clk);
    y_hi = 32'hFFFF_FFFF; lo_in = 32'd5; divisor = 32'd0; signed_mode = 1; start = 1;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    divisor = 32'd3; start = 1;
    @(negedge clk);
    start = 0;
    repeat (40) @(negedge clk);
    check("R9", "final quotient", quotient, 32'd100);
    check("R9", "final ovf", ovf, 0);

    cur_tag = "R10";
    y_hi = 32'h1234; lo_in = 32'h5678; divisor = 32'd0; signed_mode = 1;
    repeat (6) @(negedge clk);
    check("R10", "held quotient", quotient, 32'd100);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule